// File: doc/BRIEF.md
# Two-Stage Even SPI Clock Divider

This block derives the serial-clock timing of an SPI engine from a fast reference clock. A prescaler counts reference cycles, and a postscaler counts prescaler wraps. Together they divide the reference clock by `(1 + post) * pre`. The prescale value is always even, so the serial clock has a 50 percent duty cycle. The block emits a one-cycle strobe at every half-period boundary of the serial clock, which the shift engine uses to toggle SCLK. A second strobe fires on every other half-period strobe and marks the end of a full bit period.

The two divide values come in as 8-bit fields. In the surrounding control word they occupy bits 11:4 (prescale) and 19:12 (postscale). The neighbouring register decoder slices them out and drives them here. Choosing a divider pair for a target frequency is left to software. While enable is low, both counters and the period phase are held at zero, so each run starts from a clean boundary.

Top module: `sclk_two_stage_div`

## Requirements
- R1: While enabled with fixed settings, `tick_o` pulses for one cycle every `(pre/2)*(1+post)` reference cycles, so the full SCLK ratio is `(1+post)*pre`; no pulse appears in between.
- R2: With prescale 2 and postscale 0 (the minimum ratio of 2), `tick_o` is high on every cycle while enabled, after the first.
- R3: An odd prescale value behaves exactly like the even value one below it (for example 7 acts as 6 and 255 acts as 254).
- R4: A prescale value of 0 or 1 behaves as 2.
- R5: With prescale 254 and postscale 255 (the maximum ratio of 65024), the half-period is 32512 reference cycles.
- R6: While `en_i` is low, `tick_o` and `period_o` stay low from the next cycle on and all counting restarts. The first `tick_o` after `en_i` rises comes exactly one half-period after the first clock edge at which `en_i` is high, even if the previous run was stopped mid-count.
- R7: `period_o` pulses together with every second `tick_o` since enable (the 2nd, 4th, and so on), and never without `tick_o`.
- R8: While `rst_ni` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low clears the counters |
| pre_div_i | input | 8 | Prescale value (even, 2 to 254 intended) |
| post_div_i | input | 8 | Postscale value (0 to 255) |
| tick_o | output | 1 | One-cycle strobe at each SCLK half-period boundary |
| period_o | output | 1 | One-cycle strobe at the end of each full SCLK period |

## Verification
The timing assertions assume that the divide fields stay constant while `en_i` is high. Retuning is meant to happen only with the block disabled. Each directed case therefore loads new settings while `en_i` is low and holds them for the whole run. The full-rate assertion also depends on those settings being stable, and it only looks at cycles after reset has been released. The aborted-run case drops `en_i` in the middle of a count and then re-enables, to show that no leftover count shortens the next half-period.

// File: rtl/sclk_two_stage_div.sv
module sclk_two_stage_div #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] pre_div_i,
  input  logic [DW-1:0] post_div_i,
  output logic          tick_o,
  output logic          period_o
);

  logic [DW-1:0] pre_half, half_m1;
  logic [DW-1:0] pre_cnt, post_cnt;
  logic          pre_hit, post_hit, hit, phase_q;

  assign pre_half = pre_div_i >> 1;
  assign half_m1  = (pre_half == '0) ? '0 : pre_half - 1'b1;
  assign pre_hit  = pre_cnt >= half_m1;
  assign post_hit = post_cnt >= post_div_i;
  assign hit      = en_i & pre_hit & post_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
      phase_q  <= 1'b0;
      tick_o   <= 1'b0;
      period_o <= 1'b0;
    end else if (!en_i) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
      phase_q  <= 1'b0;
      tick_o   <= 1'b0;
      period_o <= 1'b0;
    end else begin
      tick_o   <= hit;
      period_o <= hit & phase_q;
      if (hit) phase_q <= ~phase_q;
      if (pre_hit) begin
        pre_cnt  <= '0;
        post_cnt <= post_hit ? '0 : post_cnt + 1'b1;
      end else begin
        pre_cnt  <= pre_cnt + 1'b1;
      end
    end
  end

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && !period_o));

  a_r6_no_tick_at_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> !tick_o);

  a_r7_period_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o |-> tick_o);

  a_r7_period_alternates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o |=> !period_o);

  a_r2_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(en_i) && $past(half_m1 == '0) && $past(post_div_i == '0))
      |-> tick_o);

endmodule

// File: tb/sclk_two_stage_div_tb_top.sv
`timescale 1ns/1ps
module sclk_two_stage_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] pre = 8'd2;
  logic [7:0] post = 8'd0;
  logic       tick, period;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  sclk_two_stage_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .pre_div_i(pre), .post_div_i(post),
    .tick_o(tick), .period_o(period)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input string req, input int p, input int q, input int ncyc);
    int h, tbad, pbad, first_bad, first_act;
    h = ((p >> 1) < 1 ? 1 : (p >> 1)) * (q + 1);
    @(negedge clk);
    en = 1'b0; pre = p[7:0]; post = q[7:0];
    repeat (2) @(negedge clk);
    check(req, "tick while disabled (R6)", int'(tick), 0);
    en = 1'b1;
    tbad = 0; pbad = 0; first_bad = -1; first_act = 0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      if (int'(tick) != int'(k % h == 0)) begin
        if (first_bad < 0) begin first_bad = k; first_act = int'(tick); end
        tbad++;
      end
      if (int'(period) != int'(k % (2*h) == 0)) pbad++;
    end
    if (first_bad >= 0)
      $display("  %s first tick mismatch at cycle %0d: tick=%0d (half-period %0d)",
               req, first_bad, first_act, h);
    check(req, "tick pattern mismatches", tbad, 0);
    check({req, "/R7"}, "period pattern mismatches", pbad, 0);
  endtask

  task automatic abort_case();
    @(negedge clk);
    en = 1'b0; pre = 8'd6; post = 8'd0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check("R6", "tick after disable", int'(tick), 0);
    end
    en = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R6", $sformatf("tick cycle %0d after re-enable", k), int'(tick), int'(k % 3 == 0));
    end
    en = 1'b0;
  endtask

  task automatic reset_case();
    en = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "tick in reset", int'(tick), 0);
    check("R8", "period in reset", int'(period), 0);
    en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    reset_case();
    run_case("R2", 2, 0, 10);
    run_case("R1", 6, 2, 40);
    run_case("R1", 4, 5, 50);
    run_case("R3", 7, 1, 30);
    run_case("R4", 0, 3, 20);
    run_case("R4", 1, 0, 8);
    abort_case();
    run_case("R5", 254, 255, 65030);
    run_case("R3", 255, 0, 400);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule